// File: doc/BRIEF.md
# Pulse Movement and Frequency Meter

This block watches a free-running 32-bit pulse count and measures how far it moves over a programmable sampling window. The window is counted in milliseconds from a one-cycle timebase strobe that the surrounding logic raises once per millisecond. In movement mode the block reports the unsigned size of the count change over each window. In frequency mode it scales that change to pulses per second and saturates at 500,000 Hz.

Software raises a start input while the meter is idle. The meter then captures the mode and the window length, keeps a busy flag high and publishes one result per window, with a one-cycle valid strobe. Windows follow each other without a gap for as long as start stays high. When start is low at the end of a window, that window's result is the last one and the busy flag drops.

Top module: `pulse_rate_meter`

## Requirements
- R1: While reset is held and in the cycle after it is released, `busy` is 0, `result_valid` is 0 and `result` is 0.
- R2: When `start` is 1 while `busy` is 0, `busy` is 1 in the following cycle, and `mode` and `window_ms` are captured at that edge. A `window_ms` of 0 runs as 1 ms and a value above 9999 runs as 9999 ms.
- R3: A window lasts exactly W strobes of `tick_ms`, where W is the effective length. Nothing is published before the W-th strobe.
- R4: With `mode`=0 (movement), `result` equals the count at the end of the window minus the count at its start, taken modulo 2^32 and read as two's complement, then made positive. It appears with `result_valid`=1 in the cycle after the edge that takes the W-th strobe.
- R5: With `mode`=1 (frequency), `result` equals floor(movement × 1000 / W), limited to at most 500,000.
- R6: While `start` remains 1, a new window begins at the same edge the previous one ends. The end count of one window is the start count of the next, and every window publishes a result.
- R7: If `start` is 0 at the end of a window, measuring stops. `busy` stays 1 until that window's result is published and falls in the same cycle that `result_valid` rises.
- R8: `start`, `mode` and `window_ms` have no effect while `busy` is 1. `result` holds its value in every cycle where `result_valid` is 0.
- R9: In frequency mode the result is published no later than 44 cycles after the edge that ends the window, provided the `tick_ms` strobes are at least 44 cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_ms | input | 1 | One-cycle strobe once per millisecond |
| count_in | input | 32 | Current value of the pulse counter |
| start | input | 1 | Begins measuring when idle; must stay high to keep measuring |
| mode | input | 1 | 0 = movement, 1 = frequency |
| window_ms | input | 14 | Requested sampling window in milliseconds |
| busy | output | 1 | High from start until the last result is published |
| result | output | 32 | Latest movement or frequency |
| result_valid | output | 1 | One-cycle strobe marking a new result |

## Verification
The bench uses the default parameters: 32-bit counts, a 14-bit window field, a 9999 ms ceiling, a scale of 1000 and a 500,000 Hz limit. Because the bench drives `tick_ms` itself, one strobe every other cycle makes the full 9999 ms window affordable, and both out-of-range window settings can be run in full. A sweep over windows 1 to 5 and a grid of deltas reaches count wrap-around, a step of exactly minus 2^31 and zero movement. Frequency runs are placed on either side of the 500,000 limit for several divisors, so both truncation and saturation occur.

// File: rtl/prm_pkg.sv
package prm_pkg;

  typedef enum logic {
    MODE_MOVE = 1'b0,
    MODE_FREQ = 1'b1
  } meas_mode_e;

  // Effective window length: zero runs as one, above the ceiling runs as the ceiling.
  function automatic int unsigned fit_window(input int unsigned req, input int unsigned ceiling);
    if (req == 0) return 1;
    if (req > ceiling) return ceiling;
    return req;
  endfunction

endpackage

// File: rtl/rpm_window_timer.sv
module rpm_window_timer #(
  parameter int WIN_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm,
  input  logic             run,
  input  logic             tick,
  input  logic [WIN_W-1:0] len_arm,
  input  logic [WIN_W-1:0] len_run,
  output logic [WIN_W-1:0] remaining,
  output logic             expire
);

  assign expire = run & tick & (remaining == WIN_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      remaining <= '0;
    end else if (arm) begin
      remaining <= len_arm;
    end else if (run && tick) begin
      remaining <= expire ? len_run : remaining - WIN_W'(1);
    end
  end

endmodule

// File: rtl/rpm_seq_divider.sv
module rpm_seq_divider #(
  parameter int NUM_W = 42,
  parameter int DEN_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [NUM_W-1:0] numer,
  input  logic [DEN_W-1:0] denom,
  output logic             active,
  output logic             done,
  output logic [NUM_W-1:0] quotient
);

  localparam int CW = $clog2(NUM_W + 1);

  logic [DEN_W-1:0] rem_q;
  logic [DEN_W-1:0] den_q;
  logic [CW-1:0]    steps;
  logic [DEN_W:0]   trial;
  logic             fits;

  assign trial = {rem_q, quotient[NUM_W-1]};
  assign fits  = trial >= {1'b0, den_q};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rem_q    <= '0;
      den_q    <= '0;
      steps    <= '0;
      quotient <= '0;
      active   <= 1'b0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      if (go) begin
        quotient <= numer;
        den_q    <= denom;
        rem_q    <= '0;
        steps    <= CW'(NUM_W);
        active   <= 1'b1;
      end else if (active) begin
        rem_q    <= fits ? DEN_W'(trial - {1'b0, den_q}) : trial[DEN_W-1:0];
        quotient <= {quotient[NUM_W-2:0], fits};
        steps    <= steps - CW'(1);
        if (steps == CW'(1)) begin
          active <= 1'b0;
          done   <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/pulse_rate_meter.sv
module pulse_rate_meter
  import prm_pkg::*;
#(
  parameter int CNT_W    = 32,
  parameter int WIN_W    = 14,
  parameter int WIN_MAX  = 9999,
  parameter int SCALE    = 1000,
  parameter int FREQ_MAX = 500000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_ms,
  input  logic [CNT_W-1:0] count_in,
  input  logic             start,
  input  logic             mode,
  input  logic [WIN_W-1:0] window_ms,
  output logic             busy,
  output logic [CNT_W-1:0] result,
  output logic             result_valid
);

  localparam int NUM_W = CNT_W + $clog2(SCALE);

  // Magnitude of a modular difference read as two's complement.
  function automatic logic [CNT_W-1:0] abs_delta(input logic [CNT_W-1:0] now_v,
                                                 input logic [CNT_W-1:0] then_v);
    logic [CNT_W-1:0] d;
    d = now_v - then_v;
    return d[CNT_W-1] ? (~d) + CNT_W'(1) : d;
  endfunction

  // Saturate a rate to the frequency ceiling.
  function automatic logic [CNT_W-1:0] cap_rate(input logic [NUM_W-1:0] q);
    return (q > NUM_W'(FREQ_MAX)) ? CNT_W'(FREQ_MAX) : q[CNT_W-1:0];
  endfunction

  logic             meas_on;
  meas_mode_e       cfg_mode;
  logic [WIN_W-1:0] cfg_win;
  logic [CNT_W-1:0] base_cnt;
  logic [WIN_W-1:0] remaining;
  logic [WIN_W-1:0] req_win;
  logic [CNT_W-1:0] movement;
  logic [NUM_W-1:0] numer;
  logic [NUM_W-1:0] quotient;
  logic             start_evt;
  logic             win_end;
  logic             div_start;
  logic             div_active;
  logic             div_done;

  assign req_win   = WIN_W'(fit_window(32'(window_ms), WIN_MAX));
  assign start_evt = start & ~busy;
  assign movement  = abs_delta(count_in, base_cnt);
  assign numer     = NUM_W'(movement) * NUM_W'(SCALE);
  assign div_start = win_end & (cfg_mode == MODE_FREQ);
  assign busy      = meas_on | div_active | div_done;

  rpm_window_timer #(.WIN_W(WIN_W)) timer_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .arm       (start_evt),
    .run       (meas_on),
    .tick      (tick_ms),
    .len_arm   (req_win),
    .len_run   (cfg_win),
    .remaining (remaining),
    .expire    (win_end)
  );

  rpm_seq_divider #(.NUM_W(NUM_W), .DEN_W(WIN_W)) div_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .go       (div_start),
    .numer    (numer),
    .denom    (cfg_win),
    .active   (div_active),
    .done     (div_done),
    .quotient (quotient)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meas_on  <= 1'b0;
      cfg_mode <= MODE_MOVE;
      cfg_win  <= WIN_W'(1);
      base_cnt <= '0;
    end else begin
      if (start_evt) begin
        meas_on  <= 1'b1;
        cfg_mode <= meas_mode_e'(mode);
        cfg_win  <= req_win;
      end else if (win_end) begin
        meas_on <= start;
      end
      if (start_evt || win_end) base_cnt <= count_in;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      result       <= '0;
      result_valid <= 1'b0;
    end else if (win_end && cfg_mode == MODE_MOVE) begin
      result       <= movement;
      result_valid <= 1'b1;
    end else if (div_done) begin
      result       <= cap_rate(quotient);
      result_valid <= 1'b1;
    end else begin
      result_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/pulse_rate_meter_chk.sv
module pulse_rate_meter_chk
  import prm_pkg::*;
#(
  parameter int CNT_W    = 32,
  parameter int WIN_W    = 14,
  parameter int FREQ_MAX = 500000
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             busy,
  input logic [CNT_W-1:0] result,
  input logic             result_valid,
  input logic             meas_on,
  input meas_mode_e       cfg_mode,
  input logic [WIN_W-1:0] cfg_win,
  input logic [WIN_W-1:0] remaining,
  input logic             div_start,
  input logic             div_active
);

  // R2
  busy_needs_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

  // R3
  window_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    meas_on |-> (remaining != '0 && remaining <= cfg_win));

  // R5
  freq_ceiling_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (result_valid && cfg_mode == MODE_FREQ) |-> result <= CNT_W'(FREQ_MAX));

  // R7
  busy_fall_publish_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> result_valid);

  // R8
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !result_valid |-> $stable(result));

  // R8
  cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (meas_on && $past(meas_on)) |-> ($stable(cfg_mode) && $stable(cfg_win)));

  // R9
  div_no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    div_start |-> !div_active);

endmodule

bind pulse_rate_meter pulse_rate_meter_chk #(
  .CNT_W(CNT_W), .WIN_W(WIN_W), .FREQ_MAX(FREQ_MAX)
) chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .result(result),
  .result_valid(result_valid), .meas_on(meas_on), .cfg_mode(cfg_mode),
  .cfg_win(cfg_win), .remaining(remaining), .div_start(div_start),
  .div_active(div_active)
);

// File: tb/pulse_rate_meter_test.sv
module pulse_rate_meter_test;

  localparam int NUM_W   = 42;
  localparam int LAT_MAX = NUM_W + 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_ms = 1'b0;
  logic [31:0] count_in = '0;
  logic        start = 1'b0;
  logic        mode = 1'b0;
  logic [13:0] window_ms = '0;
  wire         busy;
  wire  [31:0] result;
  wire         result_valid;

  int n_chk = 0;
  int n_fail = 0;
  int n_valid = 0;
  bit finished = 0;

  pulse_rate_meter uut (
    .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .count_in(count_in),
    .start(start), .mode(mode), .window_ms(window_ms), .busy(busy),
    .result(result), .result_valid(result_valid)
  );

  always #4 clk = ~clk;

  always @(posedge clk) if (rst_n && result_valid) n_valid++;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_move(input logic [31:0] b, input logic [31:0] e);
    logic [31:0] d;
    d = e - b;
    if (d[31]) d = 32'd0 - d;
    return d;
  endfunction

  function automatic logic [31:0] exp_freq(input logic [31:0] mv, input int w);
    longint unsigned q;
    q = (64'(mv) * 64'd1000) / 64'(w);
    if (q > 64'd500000) q = 64'd500000;
    return q[31:0];
  endfunction

  task automatic tick_once();
    @(negedge clk) tick_ms = 1'b1;
    @(negedge clk) tick_ms = 1'b0;
  endtask

  task automatic wait_result(output int k);
    k = 0;
    while (!result_valid && k < 200) begin
      @(negedge clk);
      k++;
    end
  endtask

  task automatic start_meas(input logic [13:0] w, input bit m, input logic [31:0] b, input bit hold);
    count_in = b; window_ms = w; mode = m; start = 1'b1;
    @(negedge clk);
    if (!hold) start = 1'b0;
    check(busy === 1'b1, "R2 busy after start", 64'(busy), 64'd1);
  endtask

  task automatic single_move(input logic [13:0] w, input int eff, input logic [31:0] b, input logic [31:0] d);
    int v0;
    start_meas(w, 1'b0, b, 1'b0);
    v0 = n_valid;
    for (int i = 1; i <= eff; i++) begin
      if (i == eff) count_in = b + d;
      tick_once();
      if (i == eff - 1)
        check(n_valid == v0 && !result_valid, "R3 early publish", 64'(n_valid - v0), 64'd0);
    end
    check(result_valid === 1'b1, "R3 publish at last tick", 64'(result_valid), 64'd1);
    check(result === exp_move(b, b + d), "R4 movement", 64'(result), 64'(exp_move(b, b + d)));
    check(busy === 1'b0, "R7 busy falls with result", 64'(busy), 64'd0);
  endtask

  task automatic single_freq(input logic [13:0] w, input int eff, input logic [31:0] b, input logic [31:0] d);
    int k;
    logic [31:0] e;
    start_meas(w, 1'b1, b, 1'b0);
    for (int i = 1; i <= eff; i++) begin
      if (i == eff) count_in = b + d;
      tick_once();
    end
    check(busy === 1'b1 && !result_valid, "R7 busy while dividing", 64'(busy), 64'd1);
    wait_result(k);
    e = exp_freq(exp_move(b, b + d), eff);
    check(k > 0 && k <= LAT_MAX, "R9 latency", 64'(k), 64'(LAT_MAX));
    check(result === e, "R5 frequency", 64'(result), 64'(e));
    check(busy === 1'b0, "R7 busy falls with result", 64'(busy), 64'd0);
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  logic [31:0] mdel [8] = '{32'd0, 32'd1, 32'hFFFFFFFF, 32'd7, 32'hFFFFFC18,
                            32'h7FFFFFFF, 32'h80000000, 32'h00012345};
  logic [31:0] fdel [10] = '{32'd0, 32'd5, 32'd499, 32'd500, 32'd501, 32'd1000,
                             32'd3499, 32'd3501, 32'hFFFFFE0C, 32'h80000000};
  int fwin [4] = '{1, 2, 3, 7};

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL R3 watchdog: actual hung expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    int k;
    logic [31:0] r;
    repeat (3) @(negedge clk);
    // R1 during reset
    check(busy === 1'b0 && result_valid === 1'b0 && result === '0, "R1 reset state",
          64'(result), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy === 1'b0 && result_valid === 1'b0 && result === '0, "R1 after release",
          64'(result), 64'd0);

    // R4 sweep over windows and deltas, base near the wrap point
    for (int w = 1; w <= 5; w++)
      for (int j = 0; j < 8; j++)
        single_move(14'(w), w, 32'hFFFFFFF0 + 32'(w), mdel[j]);

    // R2 window limits
    single_move(14'd0, 1, 32'd40, 32'd9);
    single_move(14'h3FFF, 9999, 32'd5, 32'hFFFFFF00);

    // R5 frequency sweep
    for (int w = 0; w < 4; w++)
      for (int j = 0; j < 10; j++)
        single_freq(14'(fwin[w]), fwin[w], 32'h10, fdel[j]);
    single_freq(14'd0, 1, 32'd0, 32'd321);
    single_freq(14'd9999, 9999, 32'd0, 32'd123456);

    // R6 back-to-back movement windows
    start_meas(14'd2, 1'b0, 32'd100, 1'b1);
    tick_once(); count_in = 32'd150; tick_once();
    check(result_valid === 1'b1 && result === 32'd50, "R6 first window", 64'(result), 64'd50);
    check(busy === 1'b1, "R6 still busy", 64'(busy), 64'd1);
    tick_once(); count_in = 32'd90; tick_once();
    check(result_valid === 1'b1 && result === 32'd60, "R6 second window", 64'(result), 64'd60);
    start = 1'b0;
    tick_once(); count_in = 32'd95; tick_once();
    check(result_valid === 1'b1 && result === 32'd5, "R6 last window", 64'(result), 64'd5);
    check(busy === 1'b0, "R7 stop after window", 64'(busy), 64'd0);

    // R6 back-to-back frequency windows
    start_meas(14'd1, 1'b1, 32'd0, 1'b1);
    count_in = 32'd700; tick_once(); wait_result(k);
    check(result === 32'd500000, "R6 freq first window clamp", 64'(result), 64'd500000);
    check(busy === 1'b1, "R6 freq still busy", 64'(busy), 64'd1);
    start = 1'b0;
    count_in = 32'd950; tick_once(); wait_result(k);
    check(result === 32'd250000 && k <= LAT_MAX, "R6 freq second window", 64'(result), 64'd250000);
    check(busy === 1'b0, "R7 freq stop", 64'(busy), 64'd0);

    // R8 inputs ignored while busy
    start_meas(14'd4, 1'b0, 32'd1000, 1'b0);
    tick_once(); tick_once();
    mode = 1'b1; window_ms = 14'd1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    tick_once();
    check(result_valid === 1'b0 && busy === 1'b1, "R8 window not shortened", 64'(result_valid), 64'd0);
    count_in = 32'd1077; tick_once();
    check(result_valid === 1'b1 && result === 32'd77, "R8 mode not changed", 64'(result), 64'd77);
    r = result;
    for (int i = 0; i < 10; i++) begin
      count_in = count_in + 32'd3;
      @(negedge clk);
    end
    check(result === r && result_valid === 1'b0, "R8 result holds", 64'(result), 64'(r));

    finished = 1;
    summary();
    $finish;
  end

endmodule